// File: doc/BRIEF.md
# Rule-Based Packet Steering Engine

This block decides where each received packet goes on an inline adapter with two network ports, called A and C. Every network port has its own host path, and the other network port is its peer. An upstream parser supplies one header key per packet, together with the ingress port, over a valid/ready handshake. The engine compares the key against an ordered table of rules. Each rule has a value, a per-bit mask, an action and a target. The first valid rule that matches wins. The result of that lookup, combined with a global forwarding mode, produces a 3-bit destination mask with one bit each for host, peer and drop.

There are three forwarding modes:
- Bypass: a matching packet goes to the host and a missing packet goes to the peer.
- Tap: every packet goes to the peer, and a matching packet is also copied to the host.
- Filter: a matching packet goes to the host and a missing packet is dropped.

A rule's own action can replace the mode's default for a match. Software writes or clears one rule per cycle through a wide write port, and lookups are never stalled while it does so.

Top module: `pkt_steer`

## Requirements
- R1: While reset is asserted, `outValid` and `inReady` are 0 and every rule is invalid, so a packet sent right after reset misses.
- R2: `inReady` is 1 from the first clock edge after reset is released. For each cycle with `inValid` and `inReady` both high, `outValid` is high in exactly the next cycle. `outIngress` in that cycle echoes the tuple's ingress port (0 = A, 1 = C).
- R3: A rule compares only the key bits whose mask bit is 1, so an all-zero field mask leaves that field uncompared. The key layout is: `[131:100]` source IP, `[99:68]` destination IP, `[67:52]` source L4 port, `[51:36]` destination L4 port, `[35:24]` VLAN ID, `[23:8]` ethertype, `[7:0]` IP protocol.
- R4: A rule hits only when all of its masked fields are equal at once.
- R5: When several valid rules hit, the lowest index wins and is reported on `outRuleIdx`, with `outHit` = 1.
- R6: On a miss, `outHit` = 0 and `outRuleIdx` = 0. The destination is then set by the mode. Mode 0 (bypass) and mode 1 (tap) give peer (`outDest` = 3'b010). Mode 2 (filter) gives drop (3'b001). `outDest` bits are {host, peer, drop}.
- R7: On a hit with action 0 (follow mode), the destination is host (3'b100) in bypass and filter mode, and host plus peer (3'b110) in tap mode.
- R8: On a hit with action 1 (drop), `outDest` = 3'b001 in every mode.
- R9: On a hit with action 2 (redirect), `outDest` = {target, 0}, where the 2-bit target is {host, peer}. A target of 0 gives 3'b001.
- R10: On a hit with action 3 (mirror), `outDest` is the mode's match default OR'ed with {target, 0}.
- R11: A rule write (`ruleWrValid` = 1 adds, 0 removes) takes effect for tuples accepted after the write edge. A tuple accepted in the same cycle as a write sees the old table.
- R12: Mode code 3 behaves exactly as filter mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Forwarding mode: 0 bypass, 1 tap, 2 and 3 filter |
| inValid | input | 1 | Tuple valid |
| inReady | output | 1 | Engine ready to accept a tuple |
| inKey | input | 132 | Packed header key |
| inIngress | input | 1 | Receiving network port (0 = A, 1 = C) |
| ruleWrEn | input | 1 | Rule write strobe |
| ruleWrIdx | input | 4 | Rule index to write |
| ruleWrValid | input | 1 | 1 adds or replaces the rule, 0 removes it |
| ruleWrKey | input | 132 | Rule match value |
| ruleWrMask | input | 132 | Rule compare mask (1 = compare this bit) |
| ruleWrAction | input | 2 | 0 follow, 1 drop, 2 redirect, 3 mirror |
| ruleWrTarget | input | 2 | Redirect or mirror target {host, peer} |
| outValid | output | 1 | Decision valid |
| outDest | output | 3 | Destination mask {host, peer, drop} |
| outHit | output | 1 | A rule matched |
| outRuleIdx | output | 4 | Index of the winning rule, 0 on a miss |
| outIngress | output | 1 | Ingress port of the decided tuple |

## Verification
A corrupted valid bit or rule entry shows up one cycle after the next tuple that should have hit or missed it. In that cycle the wrong `outHit` appears, and with it the mode's miss destination or a wrong `outRuleIdx`. A faulty priority order appears only when two rules hit together, so the stimulus deliberately builds overlapping rules. A write that takes effect at the wrong edge appears as a wrong decision for a tuple accepted in the same cycle as the write. The reference model compares every decision in the cycle it is due, so none of these faults can stay hidden for more than one packet.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_TAP    = 2'd1;

  localparam logic [1:0] ACT_FOLLOW   = 2'd0;
  localparam logic [1:0] ACT_DROP     = 2'd1;
  localparam logic [1:0] ACT_REDIRECT = 2'd2;
  localparam logic [1:0] ACT_MIRROR   = 2'd3;

  // destination mask bits: {host, peer, drop}
  localparam logic [2:0] DEST_HOST = 3'b100;
  localparam logic [2:0] DEST_PEER = 3'b010;
  localparam logic [2:0] DEST_DROP = 3'b001;

  typedef struct packed {
    logic capture;   // tuple accepted this cycle
    logic write;     // rule entry written this cycle
  } ctrlStrobe_t;

  function automatic logic [2:0] steerDecide(input logic [1:0] mode,
                                             input logic       hit,
                                             input logic [1:0] act,
                                             input logic [1:0] tgt);
    logic [2:0] missDef;
    logic [2:0] matchDef;
    logic [2:0] res;
    missDef  = (mode == MODE_BYPASS || mode == MODE_TAP) ? DEST_PEER : DEST_DROP;
    matchDef = (mode == MODE_TAP) ? (DEST_HOST | DEST_PEER) : DEST_HOST;
    if (!hit) begin
      res = missDef;
    end else begin
      unique case (act)
        ACT_FOLLOW:   res = matchDef;
        ACT_DROP:     res = DEST_DROP;
        ACT_REDIRECT: res = (tgt == 2'b00) ? DEST_DROP : {tgt, 1'b0};
        default:      res = matchDef | {tgt, 1'b0};
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        ruleWrEn,
  output logic        inReady,
  output ctrlStrobe_t strb
);

  logic readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign inReady      = readyQ;
  assign strb.capture = inValid & readyQ;
  assign strb.write   = ruleWrEn & readyQ;

  p_ready_after_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady);

  p_no_write_in_reset_r1: assert property (@(posedge clk)
    !rstN |-> !strb.write && !strb.capture);

endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int KEY_W     = 132,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [1:0]       mode,
  input  logic [KEY_W-1:0] inKey,
  input  logic             inIngress,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrValid,
  input  logic [KEY_W-1:0] wrKey,
  input  logic [KEY_W-1:0] wrMask,
  input  logic [1:0]       wrAction,
  input  logic [1:0]       wrTarget,
  output logic             outValid,
  output logic [2:0]       outDest,
  output logic             outHit,
  output logic [IDX_W-1:0] outIdx,
  output logic             outIngress
);

  logic [KEY_W-1:0] keyT  [NUM_RULES];
  logic [KEY_W-1:0] maskT [NUM_RULES];
  logic [1:0]       actT  [NUM_RULES];
  logic [1:0]       tgtT  [NUM_RULES];
  logic [NUM_RULES-1:0] validV;
  logic [NUM_RULES-1:0] hitV;
  logic [IDX_W-1:0]     winIdx;
  logic                 anyHit;
  logic                 idxOk;

  assign idxOk = (int'(wrIdx) < NUM_RULES);

  // valid bits are the only reset state of the table
  always_ff @(posedge clk) begin
    if (!rstN)                    validV         <= '0;
    else if (strb.write && idxOk) validV[wrIdx] <= wrValid;
  end

  always_ff @(posedge clk) begin
    if (strb.write && idxOk) begin
      keyT[wrIdx]  <= wrKey;
      maskT[wrIdx] <= wrMask;
      actT[wrIdx]  <= wrAction;
      tgtT[wrIdx]  <= wrTarget;
    end
  end

  // one masked comparator per entry
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
    assign hitV[g] = validV[g] && (((inKey ^ keyT[g]) & maskT[g]) == '0);
  end

  // lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hitV[i]) winIdx = IDX_W'(i);
    end
  end
  assign anyHit = |hitV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outDest    <= '0;
      outHit     <= 1'b0;
      outIdx     <= '0;
      outIngress <= 1'b0;
    end else begin
      outValid <= strb.capture;
      if (strb.capture) begin
        outDest    <= steerDecide(mode, anyHit, actT[winIdx], tgtT[winIdx]);
        outHit     <= anyHit;
        outIdx     <= anyHit ? winIdx : '0;
        outIngress <= inIngress;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> outValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.capture));
  p_drop_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outDest[0] |-> outDest[2:1] == 2'b00);
  p_some_dest_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outDest != 3'b000);
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outHit |-> int'(outIdx) < NUM_RULES);
  p_miss_idx_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outHit |-> outIdx == '0 && outDest != 3'b100);

endmodule

// File: rtl/pkt_steer.sv
module pkt_steer
  import steer_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int IP_W      = 32,
  parameter int L4_W      = 16,
  parameter int VLAN_W    = 12,
  parameter int ETYPE_W   = 16,
  parameter int PROTO_W   = 8,
  localparam int KEY_W    = 2 * IP_W + 2 * L4_W + VLAN_W + ETYPE_W + PROTO_W,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             inValid,
  output logic             inReady,
  input  logic [KEY_W-1:0] inKey,
  input  logic             inIngress,
  input  logic             ruleWrEn,
  input  logic [IDX_W-1:0] ruleWrIdx,
  input  logic             ruleWrValid,
  input  logic [KEY_W-1:0] ruleWrKey,
  input  logic [KEY_W-1:0] ruleWrMask,
  input  logic [1:0]       ruleWrAction,
  input  logic [1:0]       ruleWrTarget,
  output logic             outValid,
  output logic [2:0]       outDest,
  output logic             outHit,
  output logic [IDX_W-1:0] outRuleIdx,
  output logic             outIngress
);

  ctrlStrobe_t strb;

  steer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ruleWrEn(ruleWrEn),
    .inReady (inReady),
    .strb    (strb)
  );

  steer_dp #(
    .NUM_RULES(NUM_RULES),
    .KEY_W    (KEY_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mode      (mode),
    .inKey     (inKey),
    .inIngress (inIngress),
    .wrIdx     (ruleWrIdx),
    .wrValid   (ruleWrValid),
    .wrKey     (ruleWrKey),
    .wrMask    (ruleWrMask),
    .wrAction  (ruleWrAction),
    .wrTarget  (ruleWrTarget),
    .outValid  (outValid),
    .outDest   (outDest),
    .outHit    (outHit),
    .outIdx    (outRuleIdx),
    .outIngress(outIngress)
  );

endmodule

// File: tb/sim_pkt_steer.sv
module sim_pkt_steer;

  localparam int NR    = 16;
  localparam int KW    = 132;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [KW-1:0] inKey = '0;
  logic          inIngress = 1'b0;
  logic          ruleWrEn = 1'b0;
  logic [IW-1:0] ruleWrIdx = '0;
  logic          ruleWrValid = 1'b0;
  logic [KW-1:0] ruleWrKey = '0;
  logic [KW-1:0] ruleWrMask = '0;
  logic [1:0]    ruleWrAction = '0;
  logic [1:0]    ruleWrTarget = '0;
  logic          outValid;
  logic [2:0]    outDest;
  logic          outHit;
  logic [IW-1:0] outRuleIdx;
  logic          outIngress;

  always #2 clk = ~clk;

  pkt_steer u0 (.*);

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string curReq = "R1";

  // reference model state
  logic [KW-1:0] mKey  [NR];
  logic [KW-1:0] mMask [NR];
  logic [1:0]    mAct  [NR];
  logic [1:0]    mTgt  [NR];
  bit            mVal  [NR];
  bit            readyM = 0;
  bit            expValid = 0;
  logic [2:0]    expDest;
  bit            expHit;
  int            expIdx;
  bit            expIng;

  function automatic logic [KW-1:0] mk(input logic [31:0] sip, input logic [31:0] dip,
                                       input logic [15:0] sp, input logic [15:0] dp,
                                       input logic [11:0] vl, input logic [15:0] et,
                                       input logic [7:0] pr);
    return {sip, dip, sp, dp, vl, et, pr};
  endfunction

  function automatic logic [2:0] refDest(input logic [1:0] md, input bit hit,
                                         input logic [1:0] act, input logic [1:0] tgt);
    bit isTap;
    isTap = (md == 2'd1);
    if (!hit) return (md >= 2'd2) ? 3'b001 : 3'b010;
    case (act)
      2'd0: return {1'b1, isTap, 1'b0};
      2'd1: return 3'b001;
      2'd2: return (tgt == 2'b00) ? 3'b001 : {tgt, 1'b0};
      default: return {1'b1, isTap | tgt[0], 1'b0} | {tgt[1], 2'b00};
    endcase
  endfunction

  always @(posedge clk) begin : model
    int hitI;
    if (!rstN) begin
      readyM = 0;
      expValid = 0;
      for (int i = 0; i < NR; i++) mVal[i] = 0;
    end else begin
      expValid = inValid && readyM;
      if (expValid) begin
        hitI = -1;
        for (int i = 0; i < NR; i++)
          if (hitI < 0 && mVal[i] && (((inKey ^ mKey[i]) & mMask[i]) == '0)) hitI = i;
        expHit  = (hitI >= 0);
        expIdx  = expHit ? hitI : 0;
        expDest = refDest(mode, expHit, expHit ? mAct[hitI] : 2'd0,
                          expHit ? mTgt[hitI] : 2'd0);
        expIng  = inIngress;
      end
      if (ruleWrEn && readyM) begin
        mVal[ruleWrIdx]  = ruleWrValid;
        mKey[ruleWrIdx]  = ruleWrKey;
        mMask[ruleWrIdx] = ruleWrMask;
        mAct[ruleWrIdx]  = ruleWrAction;
        mTgt[ruleWrIdx]  = ruleWrTarget;
      end
      readyM = 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(rstN ? "R2" : "R1", "inReady", int'(inReady), int'(readyM));
      chk(curReq, "outValid", int'(outValid), int'(expValid));
      if (expValid && outValid) begin
        chk(curReq, "outDest", int'(outDest), int'(expDest));
        chk(curReq, "outHit", int'(outHit), int'(expHit));
        chk(curReq, "outRuleIdx", int'(outRuleIdx), expIdx);
        chk("R2", "outIngress", int'(outIngress), int'(expIng));
      end
    end
  end

  task automatic wrRule(input int idx, input bit v, input logic [KW-1:0] k,
                        input logic [KW-1:0] m, input logic [1:0] a, input logic [1:0] t);
    @(negedge clk);
    ruleWrEn = 1; ruleWrIdx = IW'(idx); ruleWrValid = v;
    ruleWrKey = k; ruleWrMask = m; ruleWrAction = a; ruleWrTarget = t;
    @(negedge clk);
    ruleWrEn = 0;
  endtask

  task automatic sendPkt(input bit ing, input logic [KW-1:0] k);
    @(negedge clk);
    inValid = 1; inIngress = ing; inKey = k;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic clearAll();
    for (int i = 0; i < NR; i++) wrRule(i, 0, '0, '0, 2'd0, 2'd0);
  endtask

  localparam logic [KW-1:0] M_DPORT = {32'h0, 32'h0, 16'h0, 16'hFFFF, 12'h0, 16'h0, 8'h0};
  localparam logic [KW-1:0] M_SIP8  = {32'hFF00_0000, 32'h0, 16'h0, 16'h0, 12'h0, 16'h0, 8'h0};
  localparam logic [KW-1:0] M_VLPR  = {32'h0, 32'h0, 16'h0, 16'h0, 12'hFFF, 16'h0, 8'hFF};

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] k;
    // R1: reset state and empty table
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    sendPkt(0, mk(32'h0a000001, 32'h0b000001, 16'd1000, 16'd80, 12'd5, 16'h0800, 8'd6));

    // R6 and R12: miss under every mode
    for (int md = 0; md < 4; md++) begin
      curReq = (md == 3) ? "R12" : "R6";
      mode = 2'(md);
      sendPkt(md[0], mk(32'h1, 32'h2, 16'd3, 16'd4, 12'd5, 16'd6, 8'd7));
    end
    mode = 2'd0;

    // R3: masked field compare, partial mask
    curReq = "R3";
    wrRule(0, 1, mk(32'h0, 32'h0, 16'h0, 16'd80, 12'h0, 16'h0, 8'h0), M_DPORT, 2'd0, 2'd0);
    sendPkt(0, mk(32'hdead_beef, 32'h1234, 16'd999, 16'd80, 12'd7, 16'h86dd, 8'd17));
    sendPkt(1, mk(32'hdead_beef, 32'h1234, 16'd999, 16'd81, 12'd7, 16'h86dd, 8'd17));
    wrRule(1, 1, mk(32'h0a00_0000, 32'h0, 16'h0, 16'h0, 12'h0, 16'h0, 8'h0), M_SIP8, 2'd0, 2'd0);
    sendPkt(0, mk(32'h0a01_0203, 32'h0, 16'h0, 16'd81, 12'h0, 16'h0, 8'h0));
    sendPkt(0, mk(32'h0b01_0203, 32'h0, 16'h0, 16'd81, 12'h0, 16'h0, 8'h0));
    clearAll();

    // R4: every masked field must match
    curReq = "R4";
    wrRule(3, 1, mk(32'h0, 32'h0, 16'h0, 16'h0, 12'd100, 16'h0, 8'd17), M_VLPR, 2'd0, 2'd0);
    sendPkt(0, mk(32'h5, 32'h6, 16'h7, 16'h8, 12'd100, 16'h0800, 8'd6));
    sendPkt(0, mk(32'h5, 32'h6, 16'h7, 16'h8, 12'd101, 16'h0800, 8'd17));
    sendPkt(1, mk(32'h5, 32'h6, 16'h7, 16'h8, 12'd100, 16'h0800, 8'd17));
    clearAll();

    // R5: lowest index wins; R11 removal exposes the next rule
    curReq = "R5";
    k = mk(32'h0a00_0001, 32'h0, 16'h0, 16'd443, 12'h0, 16'h0, 8'h0);
    wrRule(5, 1, k, M_DPORT, 2'd1, 2'd0);
    wrRule(2, 1, k, M_SIP8, 2'd2, 2'b10);
    sendPkt(0, k);
    curReq = "R11";
    wrRule(2, 0, '0, '0, 2'd0, 2'd0);
    sendPkt(0, k);
    // write and lookup in the same cycle: old table applies
    @(negedge clk);
    inValid = 1; inKey = k; inIngress = 1;
    ruleWrEn = 1; ruleWrIdx = 4'd5; ruleWrValid = 0;
    @(negedge clk);
    inValid = 0; ruleWrEn = 0;
    sendPkt(1, k);
    clearAll();

    // R7..R10: actions under every mode
    k = mk(32'h0, 32'h0, 16'h0, 16'd22, 12'h0, 16'h0, 8'h0);
    for (int md = 0; md < 3; md++) begin
      mode = 2'(md);
      curReq = "R7";
      wrRule(0, 1, k, M_DPORT, 2'd0, 2'd0);
      sendPkt(md[0], k);
      curReq = "R8";
      wrRule(0, 1, k, M_DPORT, 2'd1, 2'b11);
      sendPkt(0, k);
      curReq = "R9";
      for (int t = 0; t < 4; t++) begin
        wrRule(0, 1, k, M_DPORT, 2'd2, 2'(t));
        sendPkt(1, k);
      end
      curReq = "R10";
      for (int t = 0; t < 4; t++) begin
        wrRule(0, 1, k, M_DPORT, 2'd3, 2'(t));
        sendPkt(0, k);
      end
    end
    clearAll();

    // R5: random traffic against overlapping rules in a small key space
    curReq = "R5";
    for (int i = 0; i < 8; i++)
      wrRule(i * 2, 1, mk(32'h0, 32'h0, 16'h0, 16'($urandom_range(0, 3)), 12'h0, 16'h0,
                          8'($urandom_range(0, 3))),
             (i % 2 == 0) ? M_DPORT : (M_DPORT | M_VLPR), 2'($urandom_range(0, 3)),
             2'($urandom_range(0, 3)));
    for (int n = 0; n < 300; n++) begin
      mode = 2'($urandom_range(0, 3));
      sendPkt(1'($urandom_range(0, 1)),
              mk(32'h0, 32'h0, 16'h0, 16'($urandom_range(0, 4)), 12'h0, 16'h0,
                 8'($urandom_range(0, 3))));
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule